// File: doc/BRIEF.md
# Locked Two-Chip Program ROM Bank Mapper

This block turns a CPU address in the upper half of the 64 KiB space into a program ROM address. The ROM is treated as two chips of equal size. After reset the mapping is frozen: the CPU window 0x8000–0xFFFF always shows the first 32 KiB of the ROM, whatever the banking registers hold. The mapping stays frozen until a specific sequence is written to the halt bit of register A. That bit must first be written low, and a later write must move it from low to high. From then on the mapping follows the registers until the next reset.

Once the mapping is free, register A bit 3 chooses the chip. With the bit low, a 32 KiB bank taken from register A bits 2:1 is mapped. With the bit high, 16 KiB banks are taken from the second chip, using one of four control modes. The block also decodes an 8 KiB work RAM window at 0x6000–0x7FFF, which can be disabled. The registers are loaded elsewhere and come in as plain inputs. The translation is combinational. The only state is the lock tracker, which is updated by the register A write strobe.

Top module: `prg_bank_mapper`

## Requirements
- R1: After reset the mapper is locked. While locked, rom_addr_o equals cpu_addr_i[14:0] zero-extended, for every register value.
- R2: A write with rega_i[4]=1 does not unlock the mapper unless a write with rega_i[4]=0 has occurred since reset.
- R3: A write with rega_i[4]=1 unlocks the mapper when the previous register A write had rega_i[4]=0. The new mapping applies from the clock edge that takes the write, and not before that edge.
- R4: Once unlocked, the mapper stays unlocked through any further register A writes. Only rst_ni returns it to the locked state.
- R5: When unlocked with rega_i[3]=0, rom_addr_o = {rega_i[2:1] mod (PRG_BANKS16/2), cpu_addr_i[14:0]}.
- R6: When unlocked with rega_i[3]=1, rom_addr_o = {PRG_BANKS16/2 + sel, cpu_addr_i[13:0]}. With ctrl_mode_i of 0 or 1, sel = (regb_i[3:1]*2 + cpu_addr_i[14]) mod CNT, where CNT = PRG_BANKS16 - PRG_BANKS16/2.
- R7: With rega_i[3]=1 and ctrl_mode_i=2, sel = 0 when cpu_addr_i[14]=0, and sel = regb_i mod CNT when cpu_addr_i[14]=1.
- R8: With rega_i[3]=1 and ctrl_mode_i=3, sel = regb_i mod CNT when cpu_addr_i[14]=0, and sel = CNT-1 (the last bank of the second chip) when cpu_addr_i[14]=1.
- R9: Bank numbers in the second chip wrap modulo CNT, so regb_i values of CNT or more alias to lower banks.
- R10: ram_sel_o is 1 only when cpu_addr_i lies in 0x6000–0x7FFF and wram_dis_i=0. While it is 1, ram_addr_o = cpu_addr_i[12:0].
- R11: rom_sel_o equals cpu_addr_i[15], and rom_sel_o and ram_sel_o are never 1 together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_addr_i | input | 16 | CPU address |
| ctrl_mode_i | input | 2 | Program banking mode, taken from control register bits 3:2 |
| rega_i | input | 4 (bits 4:1) | Register A: bit 4 is the halt bit, bit 3 selects the chip, bits 2:1 select the 32 KiB bank |
| rega_wr_i | input | 1 | One-cycle strobe; a write to register A with the value on rega_i |
| regb_i | input | 4 | Register B bank number |
| wram_dis_i | input | 1 | Work RAM disable |
| rom_sel_o | output | 1 | ROM window selected |
| rom_addr_o | output | $clog2(PRG_BANKS16)+14 | ROM byte address |
| ram_sel_o | output | 1 | Work RAM selected |
| ram_addr_o | output | 13 | Work RAM byte address |

## Verification
The bench sweeps every control mode, every register B value and every register A chip and bank value, at addresses on both sides of the 0xC000 split and at the edges of each half. It runs this sweep once while locked and once while unlocked. The locked sweep shows that no register reaches the ROM address. The unlocked sweep separates the four modes and exposes the wrap of register B values above the second chip's size. Sequences of register A writes tell apart four cases: a high write with no prior low write, a low write alone, a low write followed by a high write, and later writes after unlocking. A reset in the middle of the run confirms that the "seen low" history is cleared. A stepped address sweep with the RAM enabled and disabled checks the edges of the RAM and ROM decode.

// File: rtl/prg_map_pkg.sv
package prg_map_pkg;
  typedef enum logic [1:0] {
    MODE_PAIR0  = 2'd0,
    MODE_PAIR1  = 2'd1,
    MODE_FIX_LO = 2'd2,
    MODE_FIX_HI = 2'd3
  } prg_mode_e;
endpackage

// File: rtl/prg_lock_track.sv
module prg_lock_track (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_i,
  input  logic halt_bit_i,
  output logic unlocked_o
);
  logic prev_q, seen_low_q, unlocked_q;

  // prev_q mirrors the register A halt bit, which is high after reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q     <= 1'b1;
      seen_low_q <= 1'b0;
      unlocked_q <= 1'b0;
    end else if (wr_i) begin
      prev_q <= halt_bit_i;
      if (!halt_bit_i) seen_low_q <= 1'b1;
      if (!prev_q && halt_bit_i && seen_low_q) unlocked_q <= 1'b1;
    end
  end

  assign unlocked_o = unlocked_q;

  // R4
  unlock_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unlocked_q |=> unlocked_q);

  // R3
  unlock_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(unlocked_q) |-> $past(wr_i && halt_bit_i));

  // R2
  no_early_unlock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !seen_low_q && !unlocked_q) |=> !unlocked_q);
endmodule

// File: rtl/prg_wrap.sv
module prg_wrap #(
  parameter int MOD = 4,
  parameter int IW  = 4,
  parameter int OW  = 2
) (
  input  logic [IW-1:0] val_i,
  output logic [OW-1:0] val_o
);
  localparam bit POW2 = (MOD & (MOD - 1)) == 0;

  generate
    if (POW2) begin : g_mask
      assign val_o = OW'(val_i);
    end else begin : g_div
      assign val_o = OW'(32'(val_i) % 32'(MOD));
    end
  endgenerate
endmodule

// File: rtl/prg_bank_xlate.sv
module prg_bank_xlate
  import prg_map_pkg::*;
#(
  parameter int PRG_BANKS16 = 8,
  localparam int BANK_W = $clog2(PRG_BANKS16),
  localparam int ROM_AW = BANK_W + 14
) (
  input  logic              unlocked_i,
  input  logic [14:0]       addr_i,
  input  prg_mode_e         mode_i,
  input  logic [3:1]        rega_i,
  input  logic [3:0]        regb_i,
  output logic [ROM_AW-1:0] rom_addr_o
);
  localparam int BASE    = PRG_BANKS16 / 2;
  localparam int CNT     = PRG_BANKS16 - BASE;
  localparam int SEL_W   = $clog2(CNT);
  localparam int B32_CNT = PRG_BANKS16 / 2;
  localparam int B32_W   = $clog2(B32_CNT);

  logic             hi;
  logic [3:0]       pick;
  logic             use_last;
  logic [SEL_W-1:0] wrapped;
  logic [SEL_W-1:0] sel16;
  logic [BANK_W-1:0] bank16;
  logic [B32_W-1:0] bank32;

  assign hi = addr_i[14];

  always_comb begin
    use_last = 1'b0;
    unique case (mode_i)
      MODE_PAIR0, MODE_PAIR1: pick = {regb_i[3:1], hi};
      MODE_FIX_LO:            pick = hi ? regb_i : 4'd0;
      MODE_FIX_HI: begin
        pick     = regb_i;
        use_last = hi;
      end
      default:                pick = regb_i;
    endcase
  end

  prg_wrap #(.MOD(CNT), .IW(4), .OW(SEL_W)) u_wrap16 (
    .val_i (pick),
    .val_o (wrapped)
  );

  prg_wrap #(.MOD(B32_CNT), .IW(2), .OW(B32_W)) u_wrap32 (
    .val_i (rega_i[2:1]),
    .val_o (bank32)
  );

  assign sel16  = use_last ? SEL_W'(CNT - 1) : wrapped;
  assign bank16 = BANK_W'(BASE) + BANK_W'(sel16);

  always_comb begin
    if (!unlocked_i)      rom_addr_o = ROM_AW'(addr_i);
    else if (!rega_i[3])  rom_addr_o = ROM_AW'({bank32, addr_i});
    else                  rom_addr_o = {bank16, addr_i[13:0]};
  end
endmodule

// File: rtl/wram_decode.sv
module wram_decode #(
  parameter int          RAM_AW   = 13,
  parameter logic [15:0] RAM_BASE = 16'h6000
) (
  input  logic [15:0]       addr_i,
  input  logic              dis_i,
  output logic              sel_o,
  output logic [RAM_AW-1:0] addr_o
);
  localparam logic [15-RAM_AW:0] WIN = RAM_BASE[15:RAM_AW];

  assign sel_o  = (addr_i[15:RAM_AW] == WIN) && !dis_i;
  assign addr_o = addr_i[RAM_AW-1:0];
endmodule

// File: rtl/prg_bank_mapper.sv
module prg_bank_mapper
  import prg_map_pkg::*;
#(
  parameter int PRG_BANKS16 = 8,
  localparam int ROM_AW = $clog2(PRG_BANKS16) + 14
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [15:0]       cpu_addr_i,
  input  logic [1:0]        ctrl_mode_i,
  input  logic [4:1]        rega_i,
  input  logic              rega_wr_i,
  input  logic [3:0]        regb_i,
  input  logic              wram_dis_i,
  output logic              rom_sel_o,
  output logic [ROM_AW-1:0] rom_addr_o,
  output logic              ram_sel_o,
  output logic [12:0]       ram_addr_o
);
  localparam int BANK_W = $clog2(PRG_BANKS16);
  localparam int BASE   = PRG_BANKS16 / 2;

  logic      unlocked;
  prg_mode_e mode;

  assign mode      = prg_mode_e'(ctrl_mode_i);
  assign rom_sel_o = cpu_addr_i[15];

  prg_lock_track u_lock (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (rega_wr_i),
    .halt_bit_i (rega_i[4]),
    .unlocked_o (unlocked)
  );

  prg_bank_xlate #(.PRG_BANKS16(PRG_BANKS16)) u_xlate (
    .unlocked_i (unlocked),
    .addr_i     (cpu_addr_i[14:0]),
    .mode_i     (mode),
    .rega_i     (rega_i[3:1]),
    .regb_i     (regb_i),
    .rom_addr_o (rom_addr_o)
  );

  wram_decode #(.RAM_AW(13), .RAM_BASE(16'h6000)) u_wram (
    .addr_i (cpu_addr_i),
    .dis_i  (wram_dis_i),
    .sel_o  (ram_sel_o),
    .addr_o (ram_addr_o)
  );

  // R1
  locked_map_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !unlocked |-> rom_addr_o == ROM_AW'(cpu_addr_i[14:0]));

  // R5
  first_chip_offs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (unlocked && !rega_i[3]) |-> rom_addr_o[14:0] == cpu_addr_i[14:0]);

  // R6
  second_chip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (unlocked && rega_i[3]) |-> rom_addr_o[ROM_AW-1:14] >= BANK_W'(BASE));

  // R7
  fix_lo_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (unlocked && rega_i[3] && mode == MODE_FIX_LO && !cpu_addr_i[14])
      |-> rom_addr_o[ROM_AW-1:14] == BANK_W'(BASE));

  // R8
  fix_hi_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (unlocked && rega_i[3] && mode == MODE_FIX_HI && cpu_addr_i[14])
      |-> rom_addr_o[ROM_AW-1:14] == BANK_W'(PRG_BANKS16 - 1));

  // R10
  ram_dis_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wram_dis_i |-> !ram_sel_o);

  // R11
  sel_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({rom_sel_o, ram_sel_o}));
endmodule

// File: tb/prg_bank_mapper_tb.sv
module prg_bank_mapper_tb;
  localparam int CLK_P = 10;
  localparam int N     = 8;
  localparam int BASE  = N / 2;
  localparam int CNT   = N - BASE;
  localparam int AW    = $clog2(N) + 14;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [15:0]   cpu_addr_i = '0;
  logic [1:0]    ctrl_mode_i = '0;
  logic [4:1]    rega_i = 4'b1000;
  logic          rega_wr_i = 1'b0;
  logic [3:0]    regb_i = '0;
  logic          wram_dis_i = 1'b0;
  logic          rom_sel_o;
  logic [AW-1:0] rom_addr_o;
  logic          ram_sel_o;
  logic [12:0]   ram_addr_o;

  int total = 0;
  int bad   = 0;

  always #(CLK_P/2) clk_i = ~clk_i;

  prg_bank_mapper #(.PRG_BANKS16(N)) u_dut (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cpu_addr_i  (cpu_addr_i),
    .ctrl_mode_i (ctrl_mode_i),
    .rega_i      (rega_i),
    .rega_wr_i   (rega_wr_i),
    .regb_i      (regb_i),
    .wram_dis_i  (wram_dis_i),
    .rom_sel_o   (rom_sel_o),
    .rom_addr_o  (rom_addr_o),
    .ram_sel_o   (ram_sel_o),
    .ram_addr_o  (ram_addr_o)
  );

  function automatic int exp_rom(bit unl, int a, int b, int m, int addr);
    int hi, bk;
    hi = (addr >> 14) & 1;
    if (!unl) return addr & 32'h7FFF;
    if (((a >> 3) & 1) == 0) return (((a >> 1) & 3) % (N / 2)) * 32768 + (addr & 32'h7FFF);
    case (m)
      0, 1:    bk = ((b >> 1) * 2 + hi) % CNT;
      2:       bk = hi ? (b % CNT) : 0;
      default: bk = hi ? (CNT - 1) : (b % CNT);
    endcase
    return (BASE + bk) * 16384 + (addr & 32'h3FFF);
  endfunction

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rega_wr_i = 1'b0;
    rst_ni    = 1'b0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic write_a(logic [4:0] v);
    @(negedge clk_i);
    rega_i    = v[4:1];
    rega_wr_i = 1'b1;
    @(negedge clk_i);
    rega_wr_i = 1'b0;
  endtask

  task automatic probe(string tag, bit unl, int a, int b, int m, int addr);
    @(negedge clk_i);
    rega_i      = 4'(a >> 1);
    regb_i      = 4'(b);
    ctrl_mode_i = 2'(m);
    cpu_addr_i  = 16'(addr);
    #1;
    chk(tag, int'(rom_addr_o), exp_rom(unl, a, b, m, addr));
  endtask

  task automatic sweep(string tag, bit unl);
    int addrs[6] = '{32'h8000, 32'h9234, 32'hBFFF, 32'hC000, 32'hD5A1, 32'hFFFF};
    for (int m = 0; m < 4; m++)
      for (int b = 0; b < 16; b++)
        for (int a = 0; a < 16; a += 2)
          for (int k = 0; k < 6; k++) begin
            // keep the halt bit as last written so the lock history is untouched
            probe(tag, unl, a | 16, b, m, addrs[k]);
            chk({tag, " rom_sel R11"}, int'(rom_sel_o), 1);
          end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    total++;
    bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    do_reset();
    @(negedge clk_i);
    cpu_addr_i = 16'h0000;
    #1;
    chk("R1 reset rom_sel", int'(rom_sel_o), 0);
    chk("R1 reset ram_sel", int'(ram_sel_o), 1'b0);

    // R1: locked sweep, registers must not reach the address
    sweep("R1 locked", 1'b0);

    // R2: high write with no low write before it
    write_a(5'h18);
    probe("R2 high-only stays locked", 1'b0, 5'h18, 5, 3, 32'hC123);
    write_a(5'h10);
    probe("R2 repeated high stays locked", 1'b0, 5'h18, 5, 3, 32'hC123);

    // R3: a low write alone does not unlock
    write_a(5'h08);
    probe("R3 low-only stays locked", 1'b0, 5'h08, 5, 3, 32'hC123);

    // R3: the low-to-high write unlocks at its clock edge
    @(negedge clk_i);
    rega_i     = 4'(5'h18 >> 1);
    regb_i     = 4'd5;
    ctrl_mode_i = 2'd3;
    cpu_addr_i = 16'h8123;
    rega_wr_i  = 1'b1;
    #1;
    chk("R3 before edge still locked", int'(rom_addr_o), exp_rom(1'b0, 5'h18, 5, 3, 32'h8123));
    @(negedge clk_i);
    rega_wr_i = 1'b0;
    #1;
    chk("R3 after edge unlocked", int'(rom_addr_o), exp_rom(1'b1, 5'h18, 5, 3, 32'h8123));

    // R5 R6 R7 R8 R9: unlocked sweep over all modes and bank values
    sweep("R5-9 unlocked", 1'b1);
    probe("R9 wrap mode3 b=13", 1'b1, 5'h18, 13, 3, 32'h8000);
    probe("R7 fixed low bank", 1'b1, 5'h18, 7, 2, 32'h8001);
    probe("R8 fixed last bank", 1'b1, 5'h18, 0, 3, 32'hFFFF);
    probe("R5 first chip bank 3", 1'b1, 5'h16, 0, 0, 32'hC000);

    // R4: further writes keep it unlocked
    write_a(5'h08);
    write_a(5'h06);
    probe("R4 sticky after writes", 1'b1, 5'h06, 0, 0, 32'h9000);
    write_a(5'h16);
    probe("R4 sticky after high write", 1'b1, 5'h16, 0, 0, 32'h9000);

    // R4: reset relocks; R2: the low-write history is cleared by reset
    do_reset();
    probe("R4 reset relocks", 1'b0, 5'h16, 0, 0, 32'h9000);
    write_a(5'h18);
    probe("R2 after reset high-only locked", 1'b0, 5'h18, 2, 1, 32'hE000);

    // R10 R11: decode sweep
    for (int d = 0; d < 2; d++)
      for (int i = 0; i < 256; i++) begin
        int ad;
        bit es;
        ad = (i * 256) | ((i & 1) ? 255 : 0);
        es = (ad >= 32'h6000) && (ad <= 32'h7FFF) && (d == 0);
        @(negedge clk_i);
        cpu_addr_i = 16'(ad);
        wram_dis_i = 1'(d);
        #1;
        chk("R10 ram_sel", int'(ram_sel_o), int'(es));
        if (es) chk("R10 ram_addr", int'(ram_addr_o), ad & 32'h1FFF);
        chk("R11 rom_sel", int'(rom_sel_o), (ad >> 15) & 1);
      end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule